// File: doc/BRIEF.md
# NAND Chunk ECC Syndrome Corrector

This block judges a 512-byte flash data chunk by comparing two 3-byte check codes. One code was read back from the spare area of the page. The other was recomputed over the chunk as the data was read. The two codes are XORed to form a 24-bit syndrome. The block then sorts the result into one of four outcomes:

- the chunk is clean;
- one data bit is wrong and can be repaired;
- the stored check code itself is damaged;
- the chunk cannot be repaired.

When a single data bit is wrong, the syndrome gives its position. Each syndrome byte carries complementary bit pairs, and the odd bit of each pair supplies one bit of the 9-bit byte index or the 3-bit bit index. The block reports both indices and an 8-bit flip mask. It also has a combinational repair port: a buffer walker presents each byte with its index, and the block returns the byte with the faulty bit inverted when the index matches.

A caller pulses `start` for one cycle with both codes on the inputs. One clock later `done` pulses, and the result appears on the outputs. The result stays there until the next `start`.

Top module: `ecc_syndrome_corrector`

## Requirements
- R1: When the read code equals the computed code, `status` is 00 (clean) in the cycle `done` is high.
- R2: `done` is high for exactly the one cycle that follows each cycle in which `start` was high, and low otherwise.
- R3: When every syndrome byte d satisfies ((d ^ (d>>1)) & 0x55) == 0x55, `status` is 01 (data corrected) and `flip_mask` has exactly one bit set, at position `bit_idx`. The syndrome is `ecc_read ^ ecc_calc`, and syndrome byte k is bits [8k+7:8k].
- R4: When `status` is 01, `bit_idx` bits 2, 1 and 0 equal syndrome byte 2 bits 7, 5 and 3 respectively.
- R5: When `status` is 01, `byte_idx` bit 8 equals syndrome byte 2 bit 1. Bits 7..4 equal syndrome byte 1 bits 7, 5, 3 and 1. Bits 3..0 equal syndrome byte 0 bits 7, 5, 3 and 1.
- R6: A syndrome with exactly one of its 24 bits set gives `status` 10 (check-code error). For every status other than 01, `byte_idx`, `bit_idx` and `flip_mask` are zero.
- R7: Any other non-zero syndrome gives `status` 11 (uncorrectable).
- R8: `fix_data_out` equals `fix_data_in ^ flip_mask` when `status` is 01 and `fix_index` equals `byte_idx`. Otherwise it equals `fix_data_in`.
- R9: After reset, `done` is 0, `status` is 00, and `byte_idx`, `bit_idx` and `flip_mask` are 0.
- R10: `status`, `byte_idx` and `bit_idx` hold their values while `start` is low, whatever the code inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to evaluate the codes |
| ecc_read | input | 24 | Check code read from the spare area; byte k at [8k+7:8k] |
| ecc_calc | input | 24 | Check code recomputed over the chunk |
| done | output | 1 | Result-ready pulse, one cycle after `start` |
| status | output | 2 | 00 clean, 01 corrected, 10 check-code error, 11 uncorrectable |
| byte_idx | output | 9 | Index of the faulty byte within the chunk |
| bit_idx | output | 3 | Index of the faulty bit within that byte |
| flip_mask | output | 8 | One-hot mask of the faulty bit, zero unless status is 01 |
| fix_index | input | 9 | Index of the byte offered for repair |
| fix_data_in | input | 8 | Byte offered for repair |
| fix_data_out | output | 8 | Repaired or unchanged byte |

## Verification
A wrong internal result shows on the ports at the `done` cycle, one clock after the request. A mis-routed syndrome bit moves `byte_idx` or `bit_idx` away from the position encoded in the stimulus. A wrong pair test or one-hot test changes the 2-bit status. A result register that loads without a request changes the held outputs on the next edge. The bench exposes this by moving the code inputs with `start` low. A repair-port fault changes `fix_data_out` in the same cycle for a matching or non-matching index.

// File: rtl/ecc_corr_pkg.sv
package ecc_corr_pkg;
  localparam int BYTE_W      = 8;
  localparam int ECC_BYTES   = 3;
  localparam int SYN_W       = BYTE_W * ECC_BYTES;
  localparam int CHUNK_BYTES = 512;
  localparam int IDX_W       = $clog2(CHUNK_BYTES);
  localparam int BIT_W       = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_FIXED  = 2'b01,
    ST_ECCBAD = 2'b10,
    ST_FATAL  = 2'b11
  } status_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctrl_strobe_t;

  // mask with every even bit position set
  function automatic logic [BYTE_W-1:0] even_mask();
    logic [BYTE_W-1:0] m;
    m = '0;
    for (int i = 0; i < BYTE_W; i += 2) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/ecc_corr_ctrl.sv
module ecc_corr_ctrl
  import ecc_corr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output ctrl_strobe_t strobe,
  output logic         done
);
  logic doneQ;

  always_comb strobe.capture = start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) doneQ <= 1'b0;
    else        doneQ <= start;
  end

  assign done = doneQ;

  // R2
  done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  // R2
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
endmodule

// File: rtl/ecc_corr_dp.sv
module ecc_corr_dp
  import ecc_corr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctrl_strobe_t       strobe,
  input  logic [SYN_W-1:0]   eccRead,
  input  logic [SYN_W-1:0]   eccCalc,
  output status_e            statusQ,
  output logic [IDX_W-1:0]   byteIdxQ,
  output logic [BIT_W-1:0]   bitIdxQ,
  output logic [BYTE_W-1:0]  flipMask
);
  localparam logic [BYTE_W-1:0] PAIR_MASK = even_mask();

  logic [SYN_W-1:0]     syn;
  logic [ECC_BYTES-1:0] pairOk;
  logic                 synZero, synOneHot, allPairs;
  logic [IDX_W-1:0]     locByte;
  logic [BIT_W-1:0]     locBit;
  status_e              nextStatus;
  logic [IDX_W-1:0]     nextByte;
  logic [BIT_W-1:0]     nextBit;

  assign syn = eccRead ^ eccCalc;

  // complementary pair test, one per syndrome byte
  for (genvar g = 0; g < ECC_BYTES; g++) begin : g_pair
    logic [BYTE_W-1:0] d;
    assign d         = syn[g*BYTE_W +: BYTE_W];
    assign pairOk[g] = (((d ^ (d >> 1)) & PAIR_MASK) == PAIR_MASK);
  end

  assign allPairs  = &pairOk;
  assign synZero   = (syn == '0);
  assign synOneHot = !synZero && ((syn & (syn - 1'b1)) == '0);

  // odd bits of each pair carry the location
  assign locByte = {syn[17],
                    syn[15], syn[13], syn[11], syn[9],
                    syn[7],  syn[5],  syn[3],  syn[1]};
  assign locBit  = {syn[23], syn[21], syn[19]};

  always_comb begin
    nextStatus = ST_FATAL;
    nextByte   = '0;
    nextBit    = '0;
    if (synZero) begin
      nextStatus = ST_CLEAN;
    end else if (allPairs) begin
      nextStatus = ST_FIXED;
      nextByte   = locByte;
      nextBit    = locBit;
    end else if (synOneHot) begin
      nextStatus = ST_ECCBAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ  <= ST_CLEAN;
      byteIdxQ <= '0;
      bitIdxQ  <= '0;
    end else if (strobe.capture) begin
      statusQ  <= nextStatus;
      byteIdxQ <= nextByte;
      bitIdxQ  <= nextBit;
    end
  end

  assign flipMask = (statusQ == ST_FIXED) ?
                    ({{(BYTE_W-1){1'b0}}, 1'b1} << bitIdxQ) : '0;

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> ($stable(statusQ) && $stable(byteIdxQ) && $stable(bitIdxQ)));

  // R1
  clean_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.capture && eccRead == eccCalc) |=> statusQ == ST_CLEAN);

  // R3
  fix_mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    statusQ == ST_FIXED |-> $countones(flipMask) == 1);

  // R6
  no_location_chk: assert property (@(posedge clk) disable iff (!rst_n)
    statusQ != ST_FIXED |-> (byteIdxQ == '0 && bitIdxQ == '0 && flipMask == '0));
endmodule

// File: rtl/ecc_syndrome_corrector.sv
module ecc_syndrome_corrector
  import ecc_corr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SYN_W-1:0]  ecc_read,
  input  logic [SYN_W-1:0]  ecc_calc,
  output logic              done,
  output logic [1:0]        status,
  output logic [IDX_W-1:0]  byte_idx,
  output logic [BIT_W-1:0]  bit_idx,
  output logic [BYTE_W-1:0] flip_mask,
  input  logic [IDX_W-1:0]  fix_index,
  input  logic [BYTE_W-1:0] fix_data_in,
  output logic [BYTE_W-1:0] fix_data_out
);
  ctrl_strobe_t strobe;
  status_e      statusQ;

  ecc_corr_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  ecc_corr_dp u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .eccRead  (ecc_read),
    .eccCalc  (ecc_calc),
    .statusQ  (statusQ),
    .byteIdxQ (byte_idx),
    .bitIdxQ  (bit_idx),
    .flipMask (flip_mask)
  );

  assign status = statusQ;

  assign fix_data_out = (statusQ == ST_FIXED && fix_index == byte_idx) ?
                        (fix_data_in ^ flip_mask) : fix_data_in;

  // R8
  repair_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b01 || fix_index != byte_idx) |-> fix_data_out == fix_data_in);
endmodule

// File: tb/ecc_syndrome_corrector_bench.sv
module ecc_syndrome_corrector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] ecc_read = '0, ecc_calc = '0;
  logic        done;
  logic [1:0]  status;
  logic [8:0]  byte_idx;
  logic [2:0]  bit_idx;
  logic [7:0]  flip_mask;
  logic [8:0]  fix_index = '0;
  logic [7:0]  fix_data_in = '0;
  logic [7:0]  fix_data_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ecc_syndrome_corrector u_ecc_syndrome_corrector (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ecc_read(ecc_read), .ecc_calc(ecc_calc),
    .done(done), .status(status), .byte_idx(byte_idx), .bit_idx(bit_idx),
    .flip_mask(flip_mask), .fix_index(fix_index),
    .fix_data_in(fix_data_in), .fix_data_out(fix_data_out)
  );

  // {read, calc, status, byte, bit}
  localparam logic [61:0] VEC [8] = '{
    {24'h555555, 24'h000000, 2'b01, 9'h000, 3'd0},
    {24'h123456, 24'hB89EFC, 2'b01, 9'h1FF, 3'd7},
    {24'h9A6699, 24'h000000, 2'b01, 9'h15A, 3'd5},
    {24'hC3A5F0, 24'hC3A5F0, 2'b00, 9'h000, 3'd0},
    {24'h000100, 24'h000000, 2'b10, 9'h000, 3'd0},
    {24'h800000, 24'h000000, 2'b10, 9'h000, 3'd0},
    {24'h000003, 24'h000000, 2'b11, 9'h000, 3'd0},
    {24'h555554, 24'h000000, 2'b11, 9'h000, 3'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [23:0] rd, input logic [23:0] cc);
    @(negedge clk);
    ecc_read = rd; ecc_calc = cc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 done", done, 0);
    chk("R9 status", status, 0);
    chk("R9 byte_idx", byte_idx, 0);
    chk("R9 flip_mask", flip_mask, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 8; i++) begin
      logic [1:0] es; logic [8:0] eb; logic [2:0] ei;
      es = VEC[i][11:10]; eb = VEC[i][9:1+2]; ei = VEC[i][2:0];
      eb = VEC[i][11:3];
      es = VEC[i][13:12];
      run(VEC[i][61:38], VEC[i][37:14]);
      chk("R2 done pulse", done, 1);
      chk("R1 R3 R6 R7 status", status, es);
      chk("R5 byte_idx", byte_idx, eb);
      chk("R4 bit_idx", bit_idx, ei);
      chk("R3 R6 flip_mask", flip_mask, (es == 2'b01) ? (32'd1 << ei) : 0);
      @(negedge clk);
      chk("R2 done low", done, 0);
    end

    // R8 repair port on byte 0x15A bit 5
    run(24'h9A6699, 24'h000000);
    fix_index = 9'h15A; fix_data_in = 8'h00; #1;
    chk("R8 match flips", fix_data_out, 8'h20);
    fix_data_in = 8'hFF; #1;
    chk("R8 match flips set bit", fix_data_out, 8'hDF);
    fix_index = 9'h15B; #1;
    chk("R8 mismatch passes", fix_data_out, 8'hFF);

    // R10 inputs move without start, results hold
    @(negedge clk);
    ecc_read = 24'hFFFFFF; ecc_calc = 24'h000000;
    @(negedge clk); @(negedge clk);
    chk("R10 status held", status, 2'b01);
    chk("R10 byte held", byte_idx, 9'h15A);
    chk("R10 bit held", bit_idx, 3'd5);
    chk("R2 no pulse without start", done, 0);

    // R8 no change when not corrected, even at matching index 0
    run(24'h000000, 24'h000000);
    fix_index = 9'h000; fix_data_in = 8'hA5; #1;
    chk("R8 clean passes", fix_data_out, 8'hA5);

    // R2 back-to-back starts
    @(negedge clk);
    ecc_read = 24'h800000; ecc_calc = 24'h0; start = 1'b1;
    @(negedge clk);
    chk("R2 first of pair", done, 1);
    chk("R6 first status", status, 2'b10);
    ecc_read = 24'h555555;
    @(negedge clk);
    start = 1'b0;
    chk("R2 second of pair", done, 1);
    chk("R3 second status", status, 2'b01);
    @(negedge clk);
    chk("R2 ends", done, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule